// File: doc/BRIEF.md
# Single-Slope Ramp Converter Controller

This block is the digital half of a sawtooth (single-slope) analog-to-digital converter. An external ramp generator and two comparators supply two flags. The first flag rises when the ramp passes ground. The second rises when the ramp meets the voltage being measured. The controller measures, in clock periods, the time between these two rising edges. That time is proportional to the input level, so it is the conversion result.

When a measurement ends, the controller copies the count into a result register and pulses a valid strobe. It then asks the analog side to discharge the ramp by raising a ramp-reset request. The request lasts a number of cycles set by an input. After that the controller waits for the next zero crossing, so conversions repeat without help. Large inputs therefore take longer to convert.

If the second flag has not risen by the time the count reaches full scale, the result saturates at all ones and an overrange bit is set. Both flags are synchronized with two flops, and only their rising edges act on the controller.

Top module: `ss_ramp_ctrl`

## Requirements
- R1: While and right after reset, `ramp_rst_o` is 1, and `valid_o`, `overrange_o` and `result_o` are 0.
- R2: After reset and after every result update, `ramp_rst_o` stays high for exactly max(`hold_cycles_i`, 1) clock cycles and then drops. A value of 0 is treated as 1.
- R3: Counting begins on a rising edge of `cmp_zero_i` seen while `ramp_rst_o` is low and no count is running. It ends on the next rising edge of `cmp_in_i`.
- R4: When `cmp_in_i` rises N clock edges after `cmp_zero_i` rises, with 1 <= N <= 2^CNT_W-1, `result_o` becomes N and `overrange_o` becomes 0.
- R5: If both flags rise at the same clock edge, `result_o` becomes 0 with `overrange_o` 0.
- R6: A rising edge of `cmp_in_i` while no count is running (waiting for the zero crossing) produces no `valid_o`. A later zero-to-input measurement is still correct.
- R7: If `cmp_in_i` has not risen 2^CNT_W-1 edges after the zero crossing, `result_o` becomes all ones, `overrange_o` becomes 1, and the next conversion starts.
- R8: `valid_o` is a one-cycle pulse that comes with each update. `result_o` and `overrange_o` do not change between updates.
- R9: `ramp_rst_o` is high in the same cycle as each `valid_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_zero_i | input | 1 | Comparator flag: ramp is above ground (asynchronous) |
| cmp_in_i | input | 1 | Comparator flag: ramp has reached the input voltage (asynchronous) |
| hold_cycles_i | input | HOLD_W | Length of the ramp-reset request in cycles (0 acts as 1) |
| result_o | output | CNT_W | Latest conversion result |
| valid_o | output | 1 | One-cycle strobe when `result_o` updates |
| overrange_o | output | 1 | Latest result hit full scale without an input crossing |
| ramp_rst_o | output | 1 | Request to discharge the ramp |

## Verification
The assertions check on every cycle the properties that need no knowledge of the analog timing:
- `valid_o` is a single-cycle pulse;
- the result and overrange bit stay stable between strobes;
- an overrange always reads as all ones;
- each strobe coincides with a ramp-reset request;
- the counter never wraps.

Only the bench scenarios can show the rest:
- that the count equals the spacing between the two comparator edges;
- that simultaneous edges give zero;
- that an input crossing before the zero crossing is ignored;
- that the reset request lasts the programmed length;
- that the result is correct at both sides of full scale.

// File: rtl/ss_pkg.sv
package ss_pkg;

    typedef enum logic [1:0] {
        PH_DISCHARGE = 2'd0,
        PH_ARMED     = 2'd1,
        PH_MEASURE   = 2'd2
    } phase_t;

    // channel index inside the synchronizer vector
    localparam int CH_ZERO = 0;
    localparam int CH_IN   = 1;
    localparam int CH_NUM  = 2;

    // zero length request is stretched to one cycle
    function automatic int unsigned hold_limit(input int unsigned h);
        return (h == 0) ? 1 : h;
    endfunction

endpackage

// File: rtl/ss_edge_sync.sv
module ss_edge_sync #(
    parameter int CH = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CH-1:0] din,
    output logic [CH-1:0] rise
);
    logic [CH-1:0] meta_q;
    logic [CH-1:0] sync_q;
    logic [CH-1:0] last_q;

    for (genvar g = 0; g < CH; g++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q[g] <= 1'b0;
                sync_q[g] <= 1'b0;
                last_q[g] <= 1'b0;
            end else begin
                meta_q[g] <= din[g];
                sync_q[g] <= meta_q[g];
                last_q[g] <= sync_q[g];
            end
        end
        assign rise[g] = sync_q[g] & ~last_q[g];
    end

endmodule

// File: rtl/ss_ramp_counter.sv
module ss_ramp_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         step,
    output logic [W-1:0] cnt,
    output logic         at_max
);
    localparam logic [W-1:0] FULL = {W{1'b1}};
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= ONE;
        end else if (step && cnt_q != FULL) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign cnt    = cnt_q;
    assign at_max = (cnt_q == FULL);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        ($past(cnt_q) == FULL && !$past(start)) |-> cnt_q == FULL); // R7

endmodule

// File: rtl/ss_ramp_ctrl.sv
module ss_ramp_ctrl #(
    parameter int CNT_W  = 8,
    parameter int HOLD_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_zero_i,
    input  logic              cmp_in_i,
    input  logic [HOLD_W-1:0] hold_cycles_i,
    output logic [CNT_W-1:0]  result_o,
    output logic              valid_o,
    output logic              overrange_o,
    output logic              ramp_rst_o
);
    import ss_pkg::*;

    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

    phase_t              phase_q;
    logic [HOLD_W-1:0]   hold_q;
    logic [CNT_W-1:0]    result_q;
    logic                ovr_q;
    logic                valid_q;
    logic [CH_NUM-1:0]   flags;
    logic [CH_NUM-1:0]   rise;
    logic                zero_rise;
    logic                in_rise;
    logic                cnt_start;
    logic                cnt_step;
    logic [CNT_W-1:0]    cnt;
    logic                cnt_full;
    logic [HOLD_W-1:0]   hold_last;

    assign flags[CH_ZERO] = cmp_zero_i;
    assign flags[CH_IN]   = cmp_in_i;

    ss_edge_sync #(.CH(CH_NUM)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (flags),
        .rise (rise)
    );

    assign zero_rise = rise[CH_ZERO];
    assign in_rise   = rise[CH_IN];

    assign cnt_start = (phase_q == PH_ARMED) && zero_rise && !in_rise;
    assign cnt_step  = (phase_q == PH_MEASURE) && !in_rise;

    ss_ramp_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .start  (cnt_start),
        .step   (cnt_step),
        .cnt    (cnt),
        .at_max (cnt_full)
    );

    assign hold_last = HOLD_W'(hold_limit(int'(hold_cycles_i)) - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_DISCHARGE;
            hold_q   <= '0;
            result_q <= '0;
            ovr_q    <= 1'b0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            unique case (phase_q)
                PH_DISCHARGE: begin
                    if (hold_q >= hold_last) begin
                        hold_q  <= '0;
                        phase_q <= PH_ARMED;
                    end else begin
                        hold_q <= hold_q + 1'b1;
                    end
                end
                PH_ARMED: begin
                    if (zero_rise && in_rise) begin
                        result_q <= '0;
                        ovr_q    <= 1'b0;
                        valid_q  <= 1'b1;
                        hold_q   <= '0;
                        phase_q  <= PH_DISCHARGE;
                    end else if (zero_rise) begin
                        phase_q <= PH_MEASURE;
                    end
                end
                PH_MEASURE: begin
                    if (in_rise) begin
                        result_q <= cnt;
                        ovr_q    <= 1'b0;
                        valid_q  <= 1'b1;
                        hold_q   <= '0;
                        phase_q  <= PH_DISCHARGE;
                    end else if (cnt_full) begin
                        result_q <= FULL;
                        ovr_q    <= 1'b1;
                        valid_q  <= 1'b1;
                        hold_q   <= '0;
                        phase_q  <= PH_DISCHARGE;
                    end
                end
                default: phase_q <= PH_DISCHARGE;
            endcase
        end
    end

    assign result_o    = result_q;
    assign valid_o     = valid_q;
    assign overrange_o = ovr_q;
    assign ramp_rst_o  = (phase_q == PH_DISCHARGE);

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o); // R8
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> ($stable(result_o) && $stable(overrange_o))); // R8
    AST_OVR_ALLONES: assert property (@(posedge clk) disable iff (rst)
        overrange_o |-> result_o == FULL); // R7
    AST_VALID_RESTART: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> ramp_rst_o); // R9
    AST_NO_VALID_ARMED: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ARMED && !zero_rise) |=> !valid_o); // R6

endmodule

// File: tb/ss_ramp_ctrl_tb.sv
module ss_ramp_ctrl_tb;
    localparam int CNT_W  = 8;
    localparam int HOLD_W = 4;
    localparam int FULL   = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmp_zero_i = 1'b0;
    logic              cmp_in_i = 1'b0;
    logic [HOLD_W-1:0] hold_cycles_i = 4'd2;
    logic [CNT_W-1:0]  result_o;
    logic              valid_o;
    logic              overrange_o;
    logic              ramp_rst_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int last_res = 0;
    int last_ovr = 0;

    always #2 clk = ~clk;

    ss_ramp_ctrl #(.CNT_W(CNT_W), .HOLD_W(HOLD_W)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .cmp_zero_i    (cmp_zero_i),
        .cmp_in_i      (cmp_in_i),
        .hold_cycles_i (hold_cycles_i),
        .result_o      (result_o),
        .valid_o       (valid_o),
        .overrange_o   (overrange_o),
        .ramp_rst_o    (ramp_rst_o)
    );

    function automatic int exp_res(input int n);
        return (n > FULL) ? FULL : n;
    endfunction

    function automatic int exp_ovr(input int n);
        return (n > FULL) ? 1 : 0;
    endfunction

    function automatic int exp_hold(input int h);
        return (h == 0) ? 1 : h;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // counts ramp-reset cycles starting at the current negedge
    task automatic measure_hold(input int h, input string req);
        int n = 0;
        while (ramp_rst_o) begin
            n++;
            @(negedge clk);
        end
        chk(n == exp_hold(h), req, n, exp_hold(h));
    endtask

    // one conversion with input crossing n edges after zero crossing
    task automatic convert(input int n, input int h, input bit early_in);
        while (ramp_rst_o) @(negedge clk);
        // R8: outputs held since the previous update
        chk(int'(result_o) == last_res && int'(overrange_o) == last_ovr,
            "R8_hold", int'(result_o), last_res);
        hold_cycles_i = HOLD_W'(h);
        if (early_in) begin
            cmp_in_i = 1'b1;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                // R6: input crossing without zero crossing is ignored
                chk(!valid_o, "R6_ignore", int'(valid_o), 0);
            end
            cmp_in_i = 1'b0;
            repeat (4) @(negedge clk);
        end
        repeat (2) @(negedge clk);
        cmp_zero_i = 1'b1;
        if (n == 0) begin
            cmp_in_i = 1'b1;
        end else if (n <= FULL) begin
            repeat (n) @(negedge clk);
            cmp_in_i = 1'b1;
        end
        while (!valid_o) @(negedge clk);
        chk(int'(result_o) == exp_res(n), (n == 0) ? "R5_zero" :
            (n > FULL) ? "R7_result" : "R4_count", int'(result_o), exp_res(n));
        chk(int'(overrange_o) == exp_ovr(n), (n > FULL) ? "R7_flag" : "R4_flag",
            int'(overrange_o), exp_ovr(n));
        chk(ramp_rst_o == 1'b1, "R9_restart", int'(ramp_rst_o), 1);
        last_res = exp_res(n);
        last_ovr = exp_ovr(n);
        cmp_zero_i = 1'b0;
        cmp_in_i   = 1'b0;
        @(negedge clk);
        chk(!valid_o, "R8_pulse", int'(valid_o), 0);
        if (ramp_rst_o) begin
            measure_hold(h - ((h > 1) ? 1 : 0), "R2_hold");
        end else begin
            chk(exp_hold(h) == 1, "R2_hold", 1, exp_hold(h));
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        hold_cycles_i = 4'd3;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ramp_rst_o && !valid_o && !overrange_o && result_o == '0,
            "R1_reset", int'(result_o), 0);
        rst = 1'b0;
        // R2: request length after reset
        measure_hold(3, "R2_after_reset");
        // R3, R4: directed counts
        convert(1, 2, 1'b0);
        convert(7, 0, 1'b0);
        convert(0, 1, 1'b0);
        convert(FULL, 4, 1'b0);
        convert(FULL + 1, 5, 1'b0);
        convert(40, 3, 1'b1);
        convert(FULL - 1, 1, 1'b0);
        convert(FULL + 20, 2, 1'b0);
        for (int i = 0; i < 30; i++) begin
            int n = int'($urandom_range(0, FULL + 30));
            int h = int'($urandom_range(0, 7));
            bit e = ($urandom_range(0, 5) == 0);
            convert(n, h, e);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule